// File: doc/BRIEF.md
# Parity Error Interrupt Controller

This block holds one byte-wide control and status register and the logic that turns memory parity errors into an interrupt request. Software uses a simple write port and a combinational read port to do three things. It programs a three-bit request level. It enables or disables reporting. It acknowledges a pending request by writing a one to a self-clearing bit.

An external checker sends a one-cycle error pulse. A neighbouring memory control register supplies a two-bit parity mode. The block latches a pending flag when an error arrives while reporting is enabled and the mode selects interrupts. It then presents the programmed level to the system's interrupt priority encoder. A level of zero keeps the request silent even while the flag is set.

Top module: `parity_irq_ctrl`

## Requirements
- R1: After reset, the read port returns 8'h00, the pending output is 0 and the level output is 0.
- R2: The read value is laid out as follows: bits 7 and 6 read 0, bit 5 is the pending flag, bit 4 is the enable, bit 3 (clear) always reads 0, and bits 2..0 are the programmed level.
- R3: A write loads the enable from bit 4 and the level from bits 2..0 on the clock edge. Bits 7, 6 and 5 of a write have no effect, so the pending flag cannot be set by the bus.
- R4: On an edge where the error pulse is high, the stored enable is 1 and the mode pair {parity-enable, interrupt-select} is 2'b01 or 2'b11, the pending flag is 1 after that edge.
- R5: An error pulse does not set the pending flag when the stored enable is 0 or when the mode pair is 2'b00 or 2'b10.
- R6: A write with bit 3 set clears the pending flag on that edge.
- R7: When a setting error and a clearing write arrive on the same edge, the pending flag is 1 afterwards.
- R8: The pending flag, once set, stays set until a clearing write or reset. This holds even if the enable or the mode is dropped.
- R9: The level output equals the programmed level while the pending flag is 1 and the level is non-zero. Otherwise it is 0.
- R10: If the level is rewritten while the flag is pending, the level output shows the new value right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| parErr | input | 1 | Parity error pulse from the checker |
| modeParEn | input | 1 | Parity-enable bit of the parity mode |
| modeParInt | input | 1 | Interrupt-select bit of the parity mode |
| irqPending | output | 1 | Latched pending flag |
| irqLevel | output | 3 | Active request level, 0 when idle |

## Verification
Error pulses are applied under all four mode pairs with the enable both on and off. This separates the correct gate from one that checks the wrong mode bit or ignores the enable. Directed sequences cover four cases:
- a clear landing on the same edge as an error;
- a level rewritten while a request is pending;
- a write that tries to set the pending flag;
- a level of zero with the flag set.

These show the set-over-clear priority, the live level tracking and the masking. Random writes and errors, checked every cycle against a bench model, then test the whole register under mixed traffic.

// File: rtl/parity_irq_pkg.sv
package parity_irq_pkg;
  localparam int REG_W   = 8;
  localparam int LEVEL_W = 3;
  localparam int PEND_BIT = 5;
  localparam int EN_BIT   = 4;
  localparam int CLR_BIT  = 3;

  typedef struct packed {
    logic loadCfg;
    logic clearPend;
    logic setPend;
  } ctrlStrobes_t;
endpackage

// File: rtl/parity_irq_ctrl_fsm.sv
module parity_irq_ctrl_fsm
  import parity_irq_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          wrEn,
  input  logic [RW-1:0] wrData,
  input  logic          parErr,
  input  logic          modeParEn,
  input  logic          modeParInt,
  input  logic          cfgEn,
  output ctrlStrobes_t  strobes
);
  logic [1:0] modePair;
  logic       modeOk;

  assign modePair = {modeParEn, modeParInt};
  // interrupts selected in both "01" and "11" encodings
  assign modeOk   = (modePair == 2'b01) || (modePair == 2'b11);

  always_comb begin
    strobes.loadCfg   = wrEn;
    strobes.clearPend = wrEn && wrData[CLR_BIT];
    strobes.setPend   = parErr && cfgEn && modeOk;
  end
endmodule

// File: rtl/parity_irq_datapath.sv
module parity_irq_datapath
  import parity_irq_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int LW = LEVEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [RW-1:0] wrData,
  input  ctrlStrobes_t  strobes,
  output logic          cfgEn,
  output logic [RW-1:0] rdData,
  output logic          irqPending,
  output logic [LW-1:0] irqLevel
);
  logic          pendReg;
  logic          enReg;
  logic [LW-1:0] lvlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      lvlReg <= '0;
    end else if (strobes.loadCfg) begin
      enReg  <= wrData[EN_BIT];
      lvlReg <= wrData[LW-1:0];
    end
  end

  // new error takes priority over acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)                  pendReg <= 1'b0;
    else if (strobes.setPend)   pendReg <= 1'b1;
    else if (strobes.clearPend) pendReg <= 1'b0;
  end

  always_comb begin
    rdData           = '0;
    rdData[PEND_BIT] = pendReg;
    rdData[EN_BIT]   = enReg;
    rdData[LW-1:0]   = lvlReg;
  end

  assign cfgEn      = enReg;
  assign irqPending = pendReg;
  assign irqLevel   = (pendReg && (lvlReg != '0)) ? lvlReg : '0;
endmodule

// File: rtl/parity_irq_ctrl.sv
module parity_irq_ctrl
  import parity_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               parErr,
  input  logic               modeParEn,
  input  logic               modeParInt,
  output logic               irqPending,
  output logic [LEVEL_W-1:0] irqLevel
);
  ctrlStrobes_t strobes;
  logic         cfgEn;

  parity_irq_ctrl_fsm #(.RW(REG_W)) u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .parErr(parErr),
    .modeParEn(modeParEn), .modeParInt(modeParInt),
    .cfgEn(cfgEn), .strobes(strobes)
  );

  parity_irq_datapath #(.RW(REG_W), .LW(LEVEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobes(strobes),
    .cfgEn(cfgEn), .rdData(rdData), .irqPending(irqPending),
    .irqLevel(irqLevel)
  );
endmodule

// File: rtl/parity_irq_ctrl_chk.sv
module parity_irq_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       parErr,
  input logic       modeParInt,
  input logic       irqPending,
  input logic [2:0] irqLevel
);
  logic setCond;
  assign setCond = parErr && rdData[4] && modeParInt;

  assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7:6] == 2'b00) && !rdData[3] && (rdData[5] == irqPending));
  assert_error_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    setCond |=> irqPending);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPending && !setCond) |=> !irqPending);
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[3] && !setCond) |=> !irqPending);
  assert_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !(wrEn && wrData[3])) |=> irqPending);
  assert_level_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != 3'd0) |-> (irqPending && irqLevel == rdData[2:0]));
endmodule

bind parity_irq_ctrl parity_irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .parErr(parErr), .modeParInt(modeParInt), .irqPending(irqPending),
  .irqLevel(irqLevel)
);

// File: tb/parity_irq_ctrl_bench.sv
module parity_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       parErr = 1'b0;
  logic       modeParEn = 1'b0;
  logic       modeParInt = 1'b0;
  logic       irqPending;
  logic [2:0] irqLevel;

  int checks = 0;
  int failures = 0;
  bit refPend = 1'b0;
  bit refEn = 1'b0;
  logic [2:0] refLvl = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_irq_ctrl u_parity_irq_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .parErr(parErr), .modeParEn(modeParEn), .modeParInt(modeParInt),
    .irqPending(irqPending), .irqLevel(irqLevel)
  );

  function automatic logic [7:0] expRd();
    return {2'b00, refPend, refEn, 1'b0, refLvl};
  endfunction

  function automatic logic [2:0] expLvl();
    return (refPend && refLvl != 3'd0) ? refLvl : 3'd0;
  endfunction

  task automatic check(input string req);
    checks++;
    if (rdData !== expRd() || irqPending !== refPend || irqLevel !== expLvl()) begin
      failures++;
      $display("FAIL %s rd=%h pend=%b lvl=%0d expected rd=%h pend=%b lvl=%0d",
               req, rdData, irqPending, irqLevel, expRd(), refPend, expLvl());
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step(input string req);
    bit setC;
    @(posedge clk);
    setC = parErr && refEn && modeParInt;
    if (!rstN) begin
      refPend = 0; refEn = 0; refLvl = 0;
    end else begin
      if (setC) refPend = 1;
      else if (wrEn && wrData[3]) refPend = 0;
      if (wrEn) begin refEn = wrData[4]; refLvl = wrData[2:0]; end
    end
    @(negedge clk);
    wrEn = 0; parErr = 0;
    check(req);
  endtask

  task automatic wr(input logic [7:0] d, input string req);
    wrEn = 1; wrData = d; step(req);
  endtask

  task automatic err(input bit pe, input bit pi, input string req);
    modeParEn = pe; modeParInt = pi; parErr = 1; step(req);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step("R1"); step("R1");
    rstN = 1;
    @(negedge clk); check("R1 reset state");
    // R3: pending bit not writable, top bits ignored
    wr(8'hE5, "R3 write ignores bit5");
    wr(8'h00, "R3");
    // R5: enable off, every mode
    for (int m = 0; m < 4; m++) err(m[1], m[0], "R5 enable off");
    wr(8'h13, "R3 enable level 3");
    err(1'b0, 1'b0, "R5 mode 00");
    err(1'b1, 1'b0, "R5 mode 10");
    err(1'b0, 1'b1, "R4 mode 01");
    wr(8'h1B, "R6 clear");
    err(1'b1, 1'b1, "R4 mode 11");
    // R10: move level while pending
    wr(8'h16, "R10 level 6");
    wr(8'h10, "R9 level zero masks");
    wr(8'h05, "R8 enable dropped, holds");
    modeParInt = 0; step("R8 holds");
    wr(8'h1F, "R6 clear with level 7");
    err(1'b0, 1'b1, "R4 set again");
    // R7: clear and error on same edge
    wrEn = 1; wrData = 8'h1A; modeParEn = 0; modeParInt = 1; parErr = 1;
    step("R7 error beats clear");
    wr(8'h18, "R6 final clear");
    for (int i = 0; i < 600; i++) begin
      wrEn = ($urandom % 4) == 0;
      wrData = 8'($urandom);
      parErr = ($urandom % 3) == 0;
      modeParEn = 1'($urandom);
      modeParInt = 1'($urandom);
      step("R2 R9 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule